// File: doc/BRIEF.md
# Age-Indexed Recency Queue

This block keeps a short history of the values a datapath has most recently produced, for example heap references or arithmetic results, so that later instructions can name an operand by how long ago it was produced instead of by a fixed register number. Each write inserts the new word as the youngest entry at age 0. Every older entry moves one age further back. Once the queue is full, the oldest entry is silently dropped.

Several read ports work in parallel, each addressed by an age. Each port returns the word together with a valid flag, and the flag is low when the requested age is beyond what the queue currently holds. A synchronous clear input, driven from an instruction header bit, empties the queue in one cycle. Moving entries that are about to age out into other storage is left to the surrounding control.

Top module: `recency_queue`

## Requirements
- R1: After synchronous reset every read port shows valid low and data zero, and the queue counts as empty.
- R2: A read at age 0 returns the word of the most recent write.
- R3: A read at age k returns the word written k writes before the most recent one, as long as k is below the number of held entries.
- R4: The queue holds at most DEPTH (default 16) entries. After more than DEPTH writes, age DEPTH-1 returns the DEPTH-th most recent word, and older words are gone.
- R5: A port whose age is equal to or greater than the number of held entries returns valid low and data zero.
- R6: All NRD (default 4) read ports are served in the same cycle, each with its own independent age.
- R7: Read outputs are registered. The age presented in cycle t gives its result after the clock edge that ends cycle t, and that result reflects the contents before any write taken on the same edge.
- R8: A clear without a write empties the queue, so every age reads invalid afterwards.
- R9: A clear together with a write leaves exactly one entry, the new word at age 0, and age 1 reads invalid.
- R10: All WIDTH (default 64) bits of a word are kept and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Insert wr_data_i as the youngest entry |
| wr_data_i | input | WIDTH | Word to insert |
| clr_i | input | 1 | Empty the queue (combined with wr_en_i, keeps only the new word) |
| rd_age_i | input | NRD x log2(DEPTH) | Requested age for each read port |
| rd_data_o | output | NRD x WIDTH | Registered word for each port, zero when invalid |
| rd_valid_o | output | NRD | Registered flag: the requested age was held |

## Verification
The bench uses the default parameters: DEPTH 16, four read ports and 64-bit words. With these values the operation table can write more than sixteen words between clears, so the circular head pointer wraps and eviction at age 15 is exercised. Partial fills bring the valid boundary under the four ports' independent ages, and full-width patterns with the top and bottom bits set expose truncated data paths. Directed cases cover a write and a read in the same cycle, and a clear that coincides with a write.

// File: rtl/recq_pkg.sv
package recq_pkg;

  typedef enum logic [1:0] {
    OP_HOLD       = 2'b00,
    OP_PUSH       = 2'b01,
    OP_CLEAR      = 2'b10,
    OP_CLEAR_PUSH = 2'b11
  } recq_op_e;

  function automatic recq_op_e recq_decode(input logic wr, input logic clr);
    return recq_op_e'({clr, wr});
  endfunction

endpackage

// File: rtl/recq_ctrl.sv
module recq_ctrl
  import recq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          clr_i,
  output logic [PW-1:0] head_o,
  output logic [CW-1:0] fill_o
);

  recq_op_e op;
  assign op = recq_decode(wr_en_i, clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_o <= '0;
      fill_o <= '0;
    end else begin
      unique case (op)
        OP_HOLD: ;
        OP_PUSH: begin
          head_o <= head_o + PW'(1);
          if (fill_o != CW'(DEPTH)) fill_o <= fill_o + CW'(1);
        end
        OP_CLEAR: fill_o <= '0;
        OP_CLEAR_PUSH: begin
          head_o <= head_o + PW'(1);
          fill_o <= CW'(1);
        end
      endcase
    end
  end

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill_o <= CW'(DEPTH));
  assert_full_stays_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !clr_i && fill_o == CW'(DEPTH)) |=> fill_o == CW'(DEPTH));
  assert_clear_empty_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !wr_en_i) |=> fill_o == '0);
  assert_clear_push_one_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && wr_en_i) |=> fill_o == CW'(1));
  assert_head_step_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> head_o == $past(head_o) + PW'(1));

endmodule

// File: rtl/recq_store.sv
module recq_store #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  parameter int NRD   = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we_i,
  input  logic [PW-1:0]             waddr_i,
  input  logic [WIDTH-1:0]          wdata_i,
  input  logic [NRD-1:0][PW-1:0]    raddr_i,
  output logic [NRD-1:0][WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end

endmodule

// File: rtl/recq_rdport.sv
module recq_rdport #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    age_i,
  input  logic [PW-1:0]    head_i,
  input  logic [CW-1:0]    fill_i,
  output logic [PW-1:0]    slot_o,
  input  logic [WIDTH-1:0] mem_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);

  logic held;
  assign slot_o = head_i - PW'(1) - age_i;
  assign held   = CW'(age_i) < fill_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= held;
      data_o  <= held ? mem_i : '0;
    end
  end

  assert_beyond_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (CW'(age_i) >= fill_i) |=> (!valid_o && data_o == '0));
  assert_empty_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (fill_i == '0) |=> !valid_o);

endmodule

// File: rtl/recency_queue.sv
module recency_queue #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  parameter int NRD   = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en_i,
  input  logic [WIDTH-1:0]          wr_data_i,
  input  logic                      clr_i,
  input  logic [NRD-1:0][PW-1:0]    rd_age_i,
  output logic [NRD-1:0][WIDTH-1:0] rd_data_o,
  output logic [NRD-1:0]            rd_valid_o
);

  logic [PW-1:0]             head;
  logic [CW-1:0]             fill;
  logic [NRD-1:0][PW-1:0]    slot;
  logic [NRD-1:0][WIDTH-1:0] mem_rd;

  recq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .clr_i(clr_i),
    .head_o(head), .fill_o(fill)
  );

  recq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(NRD)) store_i (
    .clk(clk), .we_i(wr_en_i), .waddr_i(head), .wdata_i(wr_data_i),
    .raddr_i(slot), .rdata_o(mem_rd)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_port
    recq_rdport #(.WIDTH(WIDTH), .DEPTH(DEPTH)) port_i (
      .clk(clk), .rst(rst), .age_i(rd_age_i[g]), .head_i(head), .fill_i(fill),
      .slot_o(slot[g]), .mem_i(mem_rd[g]),
      .data_o(rd_data_o[g]), .valid_o(rd_valid_o[g])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (rd_valid_o == '0 && rd_data_o == '0));
  assert_newest_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && rd_age_i[0] == '0) ##1 (!wr_en_i && rd_age_i[0] == '0)
      |=> (rd_valid_o[0] && rd_data_o[0] == $past(wr_data_i, 2)));

endmodule

// File: tb/recency_queue_tb_top.sv
`timescale 1ns/1ps
module recency_queue_tb_top;

  localparam int W = 64;
  localparam int D = 16;
  localparam int N = 4;
  localparam int AW = $clog2(D);

  typedef struct packed {
    logic         wr;
    logic         clr;
    logic [W-1:0] data;
    logic [4:0]   fill;
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 1'b0, 64'h1111_0000_0000_0001, 5'd1},
    '{1'b1, 1'b0, 64'h2222_0000_0000_0002, 5'd2},
    '{1'b0, 1'b0, 64'hDEAD_DEAD_DEAD_DEAD, 5'd2},
    '{1'b1, 1'b0, 64'h3333_0000_0000_0003, 5'd3},
    '{1'b0, 1'b1, 64'h0,                   5'd0},
    '{1'b1, 1'b0, 64'h8000_0000_0000_0001, 5'd1},
    '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd2},
    '{1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 5'd3},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0004, 5'd4},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0005, 5'd5},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0006, 5'd6},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0007, 5'd7},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0008, 5'd8},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0009, 5'd9},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000A, 5'd10},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000B, 5'd11},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000C, 5'd12},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000D, 5'd13},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000E, 5'd14},
    '{1'b1, 1'b0, 64'hA000_0000_0000_000F, 5'd15},
    '{1'b1, 1'b0, 64'hA000_0000_0000_0010, 5'd16},
    '{1'b1, 1'b0, 64'hB000_0000_0000_0011, 5'd16},
    '{1'b1, 1'b0, 64'hB000_0000_0000_0012, 5'd16},
    '{1'b1, 1'b1, 64'hC0DE_0000_0000_00C1, 5'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic clr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0][AW-1:0] rd_age = '0;
  logic [N-1:0][W-1:0] rd_data;
  logic [N-1:0] rd_valid;

  int total = 0;
  int bad = 0;
  logic [W-1:0] hist [D];
  int fill_m = 0;

  always #2 clk = ~clk;

  recency_queue #(.WIDTH(W), .DEPTH(D), .NRD(N)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .clr_i(clr),
    .rd_age_i(rd_age), .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_op(input logic wr, input logic c, input logic [W-1:0] d);
    if (c) fill_m = 0;
    if (wr) begin
      for (int k = D - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
      if (fill_m < D) fill_m++;
    end
  endtask

  task automatic apply(input logic wr, input logic c, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = wr; clr = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; clr = 1'b0;
    model_op(wr, c, d);
  endtask

  task automatic probe(input logic [N-1:0][AW-1:0] ages);
    @(negedge clk);
    rd_age = ages;
    @(negedge clk);
  endtask

  task automatic check_ages(input logic [N-1:0][AW-1:0] ages, input string vtag);
    probe(ages);
    for (int p = 0; p < N; p++) begin
      int a;
      logic ev;
      string dtag;
      a = int'(ages[p]);
      ev = a < fill_m;
      dtag = (a == 0) ? "R2" : (a == D - 1 && fill_m == D) ? "R4" : "R3";
      check(vtag, W'(rd_valid[p]), W'(ev));
      check(dtag, rd_data[p], ev ? hist[a] : '0);
    end
  endtask

  task automatic sweep();
    for (int b = 0; b < D; b += N) begin
      logic [N-1:0][AW-1:0] ag;
      for (int p = 0; p < N; p++) ag[p] = AW'(b + p);
      check_ages(ag, "R5");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < D; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: registered outputs cleared by reset
    for (int p = 0; p < N; p++) begin
      check("R1", W'(rd_valid[p]), '0);
      check("R1", rd_data[p], '0);
    end
    sweep();

    for (int s = 0; s < NSTEP; s++) begin
      apply(STEPS[s].wr, STEPS[s].clr, STEPS[s].data);
      check("R4", W'(fill_m), W'(STEPS[s].fill));
      sweep();
    end

    // R9: clear with write keeps only the new word
    apply(1'b1, 1'b0, 64'h5555_0000_0000_0001);
    apply(1'b1, 1'b1, 64'h9999_0000_0000_0009);
    probe({AW'(2), AW'(1), AW'(0), AW'(0)});
    check("R9", W'(rd_valid), W'(4'b0011));
    check("R9", rd_data[0], 64'h9999_0000_0000_0009);
    check("R9", rd_data[2], '0);

    // R8: clear alone empties the queue
    apply(1'b0, 1'b1, '0);
    probe('0);
    check("R8", W'(rd_valid), '0);

    // R10: full-width words survive
    apply(1'b1, 1'b0, 64'h8000_0000_0000_0001);
    apply(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE);
    probe({AW'(1), AW'(0), AW'(1), AW'(0)});
    check("R10", rd_data[0], 64'hFFFF_FFFF_FFFF_FFFE);
    check("R10", rd_data[1], 64'h8000_0000_0000_0001);

    // R6: independent ages on all ports in one cycle
    apply(1'b1, 1'b0, 64'h0000_0000_0000_0C03);
    apply(1'b1, 1'b0, 64'h0000_0000_0000_0D04);
    check_ages({AW'(1), AW'(2), AW'(0), AW'(3)}, "R6");

    // R7: a read in the write cycle sees the older contents
    @(negedge clk);
    rd_age = '0;
    wr_en = 1'b1; wr_data = 64'h7777_0000_0000_0007;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", rd_data[0], 64'h0000_0000_0000_0D04);
    model_op(1'b1, 1'b0, 64'h7777_0000_0000_0007);
    @(negedge clk);
    check("R7", rd_data[0], 64'h7777_0000_0000_0007);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule